// File: doc/BRIEF.md
# Vector Element Mask and Tail Sequencer

This block walks the elements of one vector register operation, one element per clock, and decides for each element whether the datapath computes it, whether it is overwritten with all ones, or whether it is left alone. A start pulse captures the whole configuration: start index, vector length, the mask-enable flag, the two agnostic-policy flags, the encoded register grouping, the standard element width, the operand element size, the register byte length, and the mask register. From these the block derives the total element count of the destination, including the tail, and steps an element index through the body and tail regions.

For each visited element the block raises a write enable together with a fill flag. The fill flag tells the destination to write all ones instead of the computed result. It also gives the 8-byte chunk number and the byte strobe that the element covers. When the walk is over, the block pulses done. On every completion other than an illegal grouping it also pulses a request to clear the start index. An operation whose start index has already reached the vector length finishes right away and writes nothing. The reserved grouping code is reported as an illegal configuration.

Top module: `velem_policy_ctrl`

## Requirements
- R1: When start_i is accepted with vstart_i >= vl_i and a legal grouping, done_o and vstart_clr_o pulse together in the cycle after acceptance, and wr_en_o stays low.
- R2: Elements with index below vstart_i are never written. Every index from vstart_i to vl_i-1 is visited. An active body element is written with wr_fill_o = 0, meaning computed.
- R3: With vm_i = 0, a body element whose mask bit is 0 is not computed. It is written with wr_fill_o = 1 when vma_i = 1, and not written at all when vma_i = 0. The mask bit of element i is bit i of mask_i, which is bit (i mod 64) of 64-bit word i/64.
- R4: Tail elements, with index from vl_i up to total-1, are written with wr_fill_o = 1 when vta_i = 1. When vta_i = 0 they are not written, and the walk ends after element vl_i-1.
- R5: The grouping code lmul_i is a signed 3-bit log2 value. The codes 000, 001, 010 and 011 give 1, 2, 4 and 8. The codes 101, 110 and 111 give 1/8, 1/4 and 1/2. Code 100 makes done_o and illegal_o pulse in the cycle after acceptance, with no write and no vstart_clr_o.
- R6: The total element count is (vlenb_i << e) >> esz_i, with e = max(0, esz_i - sew_i + lmul). Here sew_i and esz_i are log2 of the byte size (0 to 3).
- R7: When the grouping is below one register, the clamp on e makes the tail reach the end of the physical register.
- R8: After a normal walk, vstart_clr_o pulses together with done_o.
- R9: Visited elements appear on consecutive cycles in ascending order, starting the cycle after acceptance. done_o pulses in the cycle after the last visited element. After reset the block is idle, with busy_o, wr_en_o and done_o at 0.
- R10: A written element i of size 2^esz_i bytes has wr_chunk_o = (i << esz_i) >> 3. wr_strb_o has ones in bit positions ((i << esz_i) mod 8) up to ((i << esz_i) mod 8) + 2^esz_i - 1.
- R11: start_i is ignored while busy_o is 1, so a running walk continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, accepted when idle |
| vstart_i | input | IDX_W | First body element index |
| vl_i | input | IDX_W | Vector length |
| vm_i | input | 1 | 1 = unmasked, 0 = use mask_i |
| vma_i | input | 1 | Fill masked-off elements with ones |
| vta_i | input | 1 | Fill tail elements with ones |
| lmul_i | input | 3 | Signed log2 register grouping |
| sew_i | input | 2 | log2 of standard element width in bytes |
| esz_i | input | 2 | log2 of operand element size in bytes |
| vlenb_i | input | VLENB_W | Register length in bytes |
| mask_i | input | MAXE | Mask register, one bit per element |
| busy_o | output | 1 | Walk in progress |
| wr_en_o | output | 1 | Element write this cycle |
| wr_fill_o | output | 1 | 1 = write all ones, 0 = computed result |
| wr_idx_o | output | IDX_W | Current element index |
| wr_chunk_o | output | CHUNK_W | 8-byte chunk holding the element |
| wr_strb_o | output | 8 | Byte strobe within the chunk |
| done_o | output | 1 | Operation complete pulse |
| vstart_clr_o | output | 1 | Clear-start-index pulse |
| illegal_o | output | 1 | Reserved grouping pulse |

## Verification
The assertions check, on every cycle, the rules that hold at a single visited element. Prestart indices are never written. A computed write always has a set mask bit or no masking. A write past the vector length is always a fill with the tail flag set. The strobe width matches the element size. The index steps by one while busy. An illegal pulse never comes with a clear request. The end point of the walk depends on the total element count derived from grouping, widths and register length, and only the bench's scenarios can show that this end point is right. The same holds for which indices are written at all, for the exact chunk and strobe positions, and for start being ignored mid-walk.

// File: rtl/velem_pkg.sv
package velem_pkg;

  typedef enum logic [1:0] {
    ACT_SKIP = 2'd0,
    ACT_CALC = 2'd1,
    ACT_FILL = 2'd2
  } elem_act_e;

  // reserved grouping code
  function automatic logic grp_reserved(input logic [2:0] code);
    return code == 3'b100;
  endfunction

  // element count of the destination: (bytes << e) >> log2(size), e floored at 0
  function automatic int calc_total(input int vlenb, input logic [2:0] lmul,
                                    input logic [1:0] sew_l, input logic [1:0] esz_l);
    int e;
    e = int'(esz_l) - int'(sew_l) + int'($signed(lmul));
    if (e < 0) e = 0;
    return (vlenb << e) >> esz_l;
  endfunction

  // contiguous byte lanes for an element of 2^esz_l bytes
  function automatic logic [7:0] lane_bits(input logic [1:0] esz_l);
    case (esz_l)
      2'd0:    return 8'h01;
      2'd1:    return 8'h03;
      2'd2:    return 8'h0F;
      default: return 8'hFF;
    endcase
  endfunction

endpackage

// File: rtl/velem_total.sv
module velem_total #(
  parameter int VLENB_W = 5,
  parameter int IDX_W   = 8
) (
  input  logic [VLENB_W-1:0] vlenb_i,
  input  logic [2:0]         lmul_i,
  input  logic [1:0]         sew_i,
  input  logic [1:0]         esz_i,
  output logic [IDX_W-1:0]   total_o,
  output logic               reserved_o
);
  always_comb begin
    total_o    = IDX_W'(velem_pkg::calc_total(int'(vlenb_i), lmul_i, sew_i, esz_i));
    reserved_o = velem_pkg::grp_reserved(lmul_i);
  end
endmodule

// File: rtl/velem_classify.sv
module velem_classify #(
  parameter int IDX_W = 8,
  parameter int MAXE  = 128,
  localparam int MIDX_W = $clog2(MAXE)
) (
  input  logic [IDX_W-1:0]     idx_i,
  input  logic [IDX_W-1:0]     vl_i,
  input  logic                 vm_i,
  input  logic                 vma_i,
  input  logic                 vta_i,
  input  logic [MAXE-1:0]      mask_i,
  output velem_pkg::elem_act_e act_o
);
  logic mbit;
  assign mbit = mask_i[idx_i[MIDX_W-1:0]];

  always_comb begin
    if (idx_i >= vl_i)
      act_o = vta_i ? velem_pkg::ACT_FILL : velem_pkg::ACT_SKIP;
    else if (!vm_i && !mbit)
      act_o = vma_i ? velem_pkg::ACT_FILL : velem_pkg::ACT_SKIP;
    else
      act_o = velem_pkg::ACT_CALC;
  end
endmodule

// File: rtl/velem_strobe.sv
module velem_strobe #(
  parameter int IDX_W   = 8,
  parameter int BYTE_W  = 10,
  localparam int CHUNK_W = BYTE_W - 3
) (
  input  logic [IDX_W-1:0]   idx_i,
  input  logic [1:0]         esz_i,
  output logic [CHUNK_W-1:0] chunk_o,
  output logic [7:0]         strb_o
);
  logic [BYTE_W-1:0] byte_off;
  always_comb begin
    byte_off = BYTE_W'(idx_i) << esz_i;
    chunk_o  = byte_off[BYTE_W-1:3];
    strb_o   = velem_pkg::lane_bits(esz_i) << byte_off[2:0];
  end
endmodule

// File: rtl/velem_policy_ctrl.sv
module velem_policy_ctrl #(
  parameter int MAX_VLENB = 16,
  localparam int MAXE    = 8 * MAX_VLENB,
  localparam int IDX_W   = $clog2(MAXE + 1),
  localparam int VLENB_W = $clog2(MAX_VLENB + 1),
  localparam int BYTE_W  = $clog2(64 * MAX_VLENB),
  localparam int CHUNK_W = BYTE_W - 3,
  localparam int MIDX_W  = $clog2(MAXE)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic [IDX_W-1:0]   vstart_i,
  input  logic [IDX_W-1:0]   vl_i,
  input  logic               vm_i,
  input  logic               vma_i,
  input  logic               vta_i,
  input  logic [2:0]         lmul_i,
  input  logic [1:0]         sew_i,
  input  logic [1:0]         esz_i,
  input  logic [VLENB_W-1:0] vlenb_i,
  input  logic [MAXE-1:0]    mask_i,
  output logic               busy_o,
  output logic               wr_en_o,
  output logic               wr_fill_o,
  output logic [IDX_W-1:0]   wr_idx_o,
  output logic [CHUNK_W-1:0] wr_chunk_o,
  output logic [7:0]         wr_strb_o,
  output logic               done_o,
  output logic               vstart_clr_o,
  output logic               illegal_o
);
  import velem_pkg::*;

  // configuration captured at acceptance
  logic             busy_q;
  logic [IDX_W-1:0] idx_q, end_q, vstart_q, vl_q;
  logic             vm_q, vma_q, vta_q;
  logic [1:0]       esz_q;
  logic [MAXE-1:0]  mask_q;
  logic             done_q, clr_q, ill_q;

  // named internal events
  logic             accept_w, reserved_w, early_w, last_w;
  logic [IDX_W-1:0] total_w, end_w;
  elem_act_e        act_w;

  velem_total #(.VLENB_W(VLENB_W), .IDX_W(IDX_W)) u_total (
    .vlenb_i(vlenb_i), .lmul_i(lmul_i), .sew_i(sew_i), .esz_i(esz_i),
    .total_o(total_w), .reserved_o(reserved_w)
  );

  velem_classify #(.IDX_W(IDX_W), .MAXE(MAXE)) u_class (
    .idx_i(idx_q), .vl_i(vl_q), .vm_i(vm_q), .vma_i(vma_q), .vta_i(vta_q),
    .mask_i(mask_q), .act_o(act_w)
  );

  velem_strobe #(.IDX_W(IDX_W), .BYTE_W(BYTE_W)) u_strb (
    .idx_i(idx_q), .esz_i(esz_q), .chunk_o(wr_chunk_o), .strb_o(wr_strb_o)
  );

  assign accept_w = start_i && !busy_q;
  assign early_w  = vstart_i >= vl_i;
  // undisturbed tail: stop at vl; agnostic tail: run to the end of the group
  assign end_w    = (vta_i && (total_w > vl_i)) ? total_w : vl_i;
  assign last_w   = busy_q && (idx_q == IDX_W'(end_q - 1'b1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      idx_q    <= '0;
      end_q    <= '0;
      vstart_q <= '0;
      vl_q     <= '0;
      vm_q     <= 1'b1;
      vma_q    <= 1'b0;
      vta_q    <= 1'b0;
      esz_q    <= '0;
      mask_q   <= '0;
      done_q   <= 1'b0;
      clr_q    <= 1'b0;
      ill_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      clr_q  <= 1'b0;
      ill_q  <= 1'b0;
      if (accept_w) begin
        if (reserved_w) begin
          done_q <= 1'b1;
          ill_q  <= 1'b1;
        end else if (early_w) begin
          done_q <= 1'b1;
          clr_q  <= 1'b1;
        end else begin
          busy_q   <= 1'b1;
          idx_q    <= vstart_i;
          end_q    <= end_w;
          vstart_q <= vstart_i;
          vl_q     <= vl_i;
          vm_q     <= vm_i;
          vma_q    <= vma_i;
          vta_q    <= vta_i;
          esz_q    <= esz_i;
          mask_q   <= mask_i;
        end
      end else if (busy_q) begin
        if (last_w) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          clr_q  <= 1'b1;
        end else begin
          idx_q <= idx_q + 1'b1;
        end
      end
    end
  end

  assign busy_o       = busy_q;
  assign wr_en_o      = busy_q && (act_w != ACT_SKIP);
  assign wr_fill_o    = (act_w == ACT_FILL);
  assign wr_idx_o     = idx_q;
  assign done_o       = done_q;
  assign vstart_clr_o = clr_q;
  assign illegal_o    = ill_q;

  // R2: prestart elements are never written
  a_r2_no_prestart: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |-> (wr_idx_o >= vstart_q));

  // R3: a computed write needs an unmasked operation or a set mask bit
  a_r3_mask_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_o && !wr_fill_o) |-> (vm_q || mask_q[wr_idx_o[MIDX_W-1:0]]));

  // R4: writes past the length are tail fills under the agnostic policy only
  a_r4_tail_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_o && (wr_idx_o >= vl_q)) |-> (wr_fill_o && vta_q));

  // R5: an illegal grouping completes without a clear request and without a walk
  a_r5_illegal_done: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_o |-> (done_o && !vstart_clr_o && !busy_o));

  // R9: one element per cycle, ascending
  a_r9_idx_step: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o)) |-> (wr_idx_o == IDX_W'($past(wr_idx_o) + 1'b1)));

  // R9: completion is never reported while elements are still being visited
  a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);

  // R10: strobe width equals element size
  a_r10_strb_width: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |-> ($countones(wr_strb_o) == (1 << esz_q)));

endmodule

// File: tb/velem_policy_ctrl_bench.sv
`timescale 1ns/1ps
module velem_policy_ctrl_bench;
  localparam int MAXE    = 128;
  localparam int IDX_W   = 8;
  localparam int VLENB_W = 5;
  localparam int CHUNK_W = 7;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               start_i = 1'b0;
  logic [IDX_W-1:0]   vstart_i = '0, vl_i = '0;
  logic               vm_i = 1'b1, vma_i = 1'b0, vta_i = 1'b0;
  logic [2:0]         lmul_i = '0;
  logic [1:0]         sew_i = '0, esz_i = '0;
  logic [VLENB_W-1:0] vlenb_i = '0;
  logic [MAXE-1:0]    mask_i = '0;
  logic               busy_o, wr_en_o, wr_fill_o, done_o, vstart_clr_o, illegal_o;
  logic [IDX_W-1:0]   wr_idx_o;
  logic [CHUNK_W-1:0] wr_chunk_o;
  logic [7:0]         wr_strb_o;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  velem_policy_ctrl u_velem_policy_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .vstart_i(vstart_i), .vl_i(vl_i),
    .vm_i(vm_i), .vma_i(vma_i), .vta_i(vta_i), .lmul_i(lmul_i), .sew_i(sew_i),
    .esz_i(esz_i), .vlenb_i(vlenb_i), .mask_i(mask_i), .busy_o(busy_o),
    .wr_en_o(wr_en_o), .wr_fill_o(wr_fill_o), .wr_idx_o(wr_idx_o),
    .wr_chunk_o(wr_chunk_o), .wr_strb_o(wr_strb_o), .done_o(done_o),
    .vstart_clr_o(vstart_clr_o), .illegal_o(illegal_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // kinds: 0 none, 1 computed, 2 ones
  task automatic run_case(input string req, input int vs, input int vl,
                          input bit vm, input bit vma, input bit vta,
                          input int lm, input int sw, input int ez, input int vb,
                          input logic [127:0] mk, input bit poke);
    int exp_k[256];
    int obs_k[256];
    int total, e, lms, endi, expn, n, seq_err, strb_err, kind_err, bad_i;
    bit rsv, early, got_done, got_clr, got_ill, extra_done;
    rsv = (lm == 4);
    lms = (lm >= 4) ? lm - 8 : lm;
    e = ez - sw + lms;
    if (e < 0) e = 0;
    total = (vb * (1 << e)) / (1 << ez);
    early = !rsv && (vs >= vl);
    for (int i = 0; i < 256; i++) begin
      obs_k[i] = 0;
      exp_k[i] = 0;
      if (rsv || early || i < vs) exp_k[i] = 0;
      else if (i < vl) exp_k[i] = (vm || mk[i % 128]) ? 1 : (vma ? 2 : 0);
      else if (i < total && vta) exp_k[i] = 2;
    end
    endi = (vta && total > vl) ? total : vl;
    expn = (rsv || early) ? 0 : endi - vs;

    @(negedge clk);
    vstart_i = IDX_W'(vs); vl_i = IDX_W'(vl); vm_i = vm; vma_i = vma; vta_i = vta;
    lmul_i = 3'(lm); sew_i = 2'(sw); esz_i = 2'(ez); vlenb_i = VLENB_W'(vb); mask_i = mk;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    n = 0; got_done = 0; got_clr = 0; got_ill = 0;
    seq_err = 0; strb_err = 0; kind_err = 0; bad_i = -1;
    while (!got_done && n < 400) begin
      if (wr_en_o) begin
        int i, b, sb;
        i = int'(wr_idx_o);
        if (i != vs + n) seq_err++;
        obs_k[i] = wr_fill_o ? 2 : 1;
        b = i << ez;
        sb = ((1 << (1 << ez)) - 1) << (b % 8);
        if (int'(wr_chunk_o) != b / 8 || int'(wr_strb_o) != (sb & 255)) strb_err++;
      end
      if (done_o) begin
        got_done = 1; got_clr = vstart_clr_o; got_ill = illegal_o;
      end else begin
        n++;
        @(negedge clk);
        if (poke && n == 1) begin start_i = 1'b1; vstart_i = '0; vl_i = 8'd1; vta_i = 1'b0; end
        if (poke && n == 2) start_i = 1'b0;
      end
    end
    start_i = 1'b0;
    for (int i = 0; i < 256; i++)
      if (obs_k[i] != exp_k[i]) begin
        kind_err++;
        if (bad_i < 0) bad_i = i;
      end
    chk(got_done, req, "done seen", int'(got_done), 1);
    chk(n == expn, "R9", "cycles to done", n, expn);
    chk(kind_err == 0, req, "element kinds (first bad index)", bad_i,
        (bad_i < 0) ? -1 : exp_k[bad_i < 0 ? 0 : bad_i]);
    chk(seq_err == 0, "R9", "ascending one per cycle errors", seq_err, 0);
    chk(strb_err == 0, "R10", "chunk/strobe errors", strb_err, 0);
    chk(got_clr == !rsv, rsv ? "R5" : "R8", "vstart clear", int'(got_clr), int'(!rsv));
    chk(got_ill == rsv, "R5", "illegal flag", int'(got_ill), int'(rsv));
    extra_done = 0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      if (done_o || wr_en_o || busy_o) extra_done = 1;
    end
    if (poke) chk(!extra_done, "R11", "activity after ignored start", int'(extra_done), 0);
  endtask

  task automatic t_reset;
    chk(!busy_o && !wr_en_o && !done_o, "R9", "idle after reset",
        int'({busy_o, wr_en_o, done_o}), 0);
  endtask

  task automatic t_body_tail;   // R2 R4 R6
    run_case("R2", 0, 10, 1, 0, 1, 0, 0, 0, 16, '0, 0);
    run_case("R4", 3, 9, 1, 0, 0, 0, 0, 0, 16, '0, 0);
  endtask

  task automatic t_mask;        // R3
    run_case("R3", 1, 14, 0, 1, 1, 1, 1, 1, 16, 128'h0000_0000_0000_0000_0000_0000_0000_A5C3, 0);
    run_case("R3", 0, 12, 0, 0, 0, 0, 0, 0, 16, 128'h0000_0000_0000_0000_0000_0000_0000_0F69, 0);
  endtask

  task automatic t_early;       // R1
    run_case("R1", 7, 7, 1, 0, 1, 0, 0, 0, 16, '0, 0);
    run_case("R1", 0, 0, 1, 0, 1, 0, 0, 0, 16, '0, 0);
    run_case("R1", 9, 4, 0, 1, 1, 0, 0, 0, 16, '1, 0);
  endtask

  task automatic t_reserved;    // R5
    run_case("R5", 0, 5, 1, 1, 1, 4, 0, 0, 16, '0, 0);
  endtask

  task automatic t_fraction;    // R7 R6
    run_case("R7", 0, 5, 1, 0, 1, 7, 0, 0, 16, '0, 0);
    run_case("R7", 2, 3, 1, 0, 1, 5, 1, 1, 16, '0, 0);
  endtask

  task automatic t_wide;        // R6 R3 second mask word, R10
    run_case("R6", 0, 100, 0, 1, 1, 3, 0, 1, 16,
             128'h0000_0000_F0F0_3C3C_A5A5_0000_FFFF_1234, 0);
    run_case("R6", 0, 3, 1, 0, 1, 0, 0, 2, 8, '0, 0);
    run_case("R10", 0, 1, 1, 0, 1, 0, 3, 3, 16, '0, 0);
  endtask

  task automatic t_busy_start;  // R11
    run_case("R11", 0, 8, 1, 0, 1, 0, 0, 0, 16, '0, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_body_tail();
    t_mask();
    t_early();
    t_reserved();
    t_fraction();
    t_wide();
    t_busy_start();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(4 * 200000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule